// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Registered Status Word

This block computes a 32-bit result from two operands under a 6-bit operation code, and holds a 32-bit status word that records four condition flags of the last committed operation. The result path has no registers: the value appears in the same cycle as the operands. The status word is registered. It changes on a rising clock edge only when the update-enable input is high and the operation code is one the unit recognises.

The unit performs addition, subtraction, bitwise AND, OR, XOR and NOT, compare, logical left and right shifts, and left and right rotates. A 5-bit amount gives shifts and rotates any distance from 0 to 31. Compare subtracts and sets the flags from the difference, but it keeps the write strobe low so that no register is written. Codes outside the ALU set, such as memory loads and stores decoded elsewhere, produce a zero result and a low write strobe. They leave the status word untouched even when update-enable is high.

Top module: `alu_status_unit`

## Requirements
- R1: Opcode 6'h01 gives a + b and opcode 6'h02 gives a - b, both modulo 2^32. On a committed operation, status bit 1 (carry) holds the carry out of the addition, or for subtraction a borrow, meaning a < b unsigned.
- R2: On a committed add or subtract, status bit 3 (overflow) is set exactly when the result overflows as a signed value. For add this is when the operands share a sign and the result sign differs. For subtract this is when the operand signs differ and the result sign differs from a.
- R3: On a committed operation, status bit 0 (zero) is set exactly when the 32-bit result (or the compare difference) is all zeros.
- R4: On a committed operation, status bit 2 (parity) is set when the result holds an odd number of ones and cleared when the count is even.
- R5: Opcodes 6'h03, 6'h04 and 6'h05 give a AND b, a OR b and a XOR b. Opcode 6'h06 gives NOT a. When committed, these operations clear carry and overflow.
- R6: Opcode 6'h08 shifts a left and 6'h09 shifts a right, both logical with zero fill, by the shift amount (0 to 31). When committed, they clear carry and overflow.
- R7: Opcode 6'h0A rotates a left and 6'h0B rotates a right by the shift amount, with no bit lost. An amount of zero returns a unchanged. When committed, rotates clear carry and overflow.
- R8: Opcode 6'h07 (compare) sets all four flags as subtract would, while the write strobe res_wr stays low. res_wr is high for every other recognised opcode.
- R9: The status word changes only on a clock edge where flag_we is high and the opcode is 6'h01 to 6'h0B. Any other opcode yields result 0 and res_wr low, and leaves the status word unchanged.
- R10: A high rst on a clock edge clears the whole status word. Status bits 31 down to 4 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 6 | Operation select |
| opnd_a | input | 32 | First operand (the one shifted, rotated or inverted) |
| opnd_b | input | 32 | Second operand |
| shamt | input | 5 | Shift or rotate distance |
| flag_we | input | 1 | Commit flags of this operation on the next edge |
| alu_result | output | 32 | Combinational result |
| res_wr | output | 1 | Result should be written to a register |
| status_word | output | 32 | Registered flags: bit0 zero, bit1 carry, bit2 parity, bit3 overflow |

## Verification
The bench goes after the points where a flag depends on the direction of the operation. 0xFFFFFFFF + 1 must raise carry and zero together. 1 - 2 must show a borrow, and a design that forwards the raw adder carry on subtraction would report it inverted. 0x7FFFFFFF + 1 and 0x80000000 - 1 must raise overflow, and a rule that tests only the result sign would miss one of them. Rotates by 0 and by 31 catch stage-ordering or wrap errors in the shifter. A compare of equal values must set zero without asserting the write strobe. Opcodes outside the set, and cycles with update-enable low, must leave a known non-zero status word intact.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;
  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OPC_ADD = 6'h01,
    OPC_SUB = 6'h02,
    OPC_AND = 6'h03,
    OPC_OR  = 6'h04,
    OPC_XOR = 6'h05,
    OPC_NOT = 6'h06,
    OPC_CMP = 6'h07,
    OPC_SLL = 6'h08,
    OPC_SRL = 6'h09,
    OPC_ROL = 6'h0A,
    OPC_ROR = 6'h0B
  } alu_op_e;

  // flag bit positions inside the status word
  localparam int FLG_ZERO = 0;
  localparam int FLG_CARRY = 1;
  localparam int FLG_PARITY = 2;
  localparam int FLG_OVF = 3;
  localparam int FLG_N = 4;

  typedef struct packed {
    logic ovf;
    logic parity;
    logic carry;
    logic zero;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    // for subtraction the adder carry is the inverse of a borrow
    carry = sub ? ~wide[W] : wide[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          rotate,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int K = 1 << i;
    logic [W-1:0] moved;
    always_comb begin
      if (left) begin
        if (rotate) moved = {stage[i][W-1-K:0], stage[i][W-1:W-K]};
        else        moved = {stage[i][W-1-K:0], {K{1'b0}}};
      end else begin
        if (rotate) moved = {stage[i][K-1:0], stage[i][W-1:K]};
        else        moved = {{K{1'b0}}, stage[i][W-1:K]};
      end
    end
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg #(
  parameter int SW_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  alu_status_pkg::alu_flags_t flags_in,
  output logic [SW_W-1:0]          status
);
  localparam int NF = alu_status_pkg::FLG_N;

  logic [NF-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= '0;
    else if (upd) flag_q <= flags_in;
  end

  assign status = {{(SW_W-NF){1'b0}}, flag_q};
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   shamt,
  input  logic              flag_we,
  output logic [DATA_W-1:0] alu_result,
  output logic              res_wr,
  output logic [STAT_W-1:0] status_word
);
  logic [DATA_W-1:0] as_sum, sh_out, val;
  logic              as_carry, as_ovf, is_sub, known;
  logic              sh_left, sh_rot, arith_op;
  alu_flags_t        nxt;

  assign is_sub  = (op_code == OPC_SUB) || (op_code == OPC_CMP);
  assign sh_left = (op_code == OPC_SLL) || (op_code == OPC_ROL);
  assign sh_rot  = (op_code == OPC_ROL) || (op_code == OPC_ROR);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(is_sub),
    .sum(as_sum), .carry(as_carry), .ovf(as_ovf)
  );

  alu_barrel #(.W(DATA_W)) u_barrel (
    .din(opnd_a), .amt(shamt), .left(sh_left), .rotate(sh_rot),
    .dout(sh_out)
  );

  always_comb begin
    known    = 1'b1;
    arith_op = 1'b0;
    val      = '0;
    unique case (op_code)
      OPC_ADD, OPC_SUB, OPC_CMP: begin val = as_sum; arith_op = 1'b1; end
      OPC_AND: val = opnd_a & opnd_b;
      OPC_OR:  val = opnd_a | opnd_b;
      OPC_XOR: val = opnd_a ^ opnd_b;
      OPC_NOT: val = ~opnd_a;
      OPC_SLL, OPC_SRL, OPC_ROL, OPC_ROR: val = sh_out;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    nxt.zero   = (val == '0);
    nxt.parity = ^val;
    nxt.carry  = arith_op & as_carry;
    nxt.ovf    = arith_op & as_ovf;
  end

  assign alu_result = val;
  assign res_wr     = known && (op_code != OPC_CMP);

  alu_status_reg #(.SW_W(STAT_W)) u_status (
    .clk(clk), .rst(rst), .upd(flag_we && known),
    .flags_in(nxt), .status(status_word)
  );
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk (
  input logic        clk,
  input logic        rst,
  input logic [5:0]  op_code,
  input logic [31:0] opnd_a,
  input logic [4:0]  shamt,
  input logic        flag_we,
  input logic [31:0] alu_result,
  input logic        res_wr,
  input logic [31:0] status_word
);
  logic in_set, commit, no_arith;
  assign in_set   = (op_code >= 6'h01) && (op_code <= 6'h0B);
  assign commit   = flag_we && in_set;
  assign no_arith = in_set && (op_code != 6'h01) && (op_code != 6'h02) && (op_code != 6'h07);

  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
    status_word[31:4] == '0);
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> status_word == '0);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(status_word));
  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> status_word[0] == ($past(alu_result) == 32'd0));
  assert_parity_flag_R4: assert property (@(posedge clk) disable iff (rst)
    commit |=> status_word[2] == $past(^alu_result));
  assert_clear_cv_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_we && no_arith) |=> (status_word[1] == 1'b0 && status_word[3] == 1'b0));
  assert_rot_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ((op_code == 6'h0A || op_code == 6'h0B) && shamt == 5'd0) |-> alu_result == opnd_a);
  assert_cmp_nowr_R8: assert property (@(posedge clk) disable iff (rst)
    (op_code == 6'h07) |-> !res_wr);
  assert_foreign_R9: assert property (@(posedge clk) disable iff (rst)
    !in_set |-> (alu_result == 32'd0 && !res_wr));
endmodule

bind alu_status_unit alu_status_chk u_chk (
  .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .shamt(shamt),
  .flag_we(flag_we), .alu_result(alu_result), .res_wr(res_wr),
  .status_word(status_word)
);

// File: tb/test_alu_status_unit.sv
module test_alu_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic        flag_we = 1'b0;
  logic [31:0] alu_result, status_word;
  logic        res_wr;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] model_flags = '0;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic [31:0] stat;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  alu_status_unit i_alu_status_unit (
    .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shamt(shamt), .flag_we(flag_we), .alu_result(alu_result), .res_wr(res_wr),
    .status_word(status_word)
  );

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: applies one operation and pushes the expected outcome
  task automatic drive(string tag, logic [5:0] op, logic [31:0] a, logic [31:0] b,
                       logic [4:0] s, logic we);
    logic [32:0] w;
    logic [31:0] r;
    logic c, v, ok, arith;
    exp_t e;
    ok = 1'b1; arith = 1'b0; r = '0; c = 1'b0; v = 1'b0;
    case (op)
      6'h01: begin w = {1'b0, a} + {1'b0, b}; r = w[31:0]; c = w[32];
                   v = (a[31] == b[31]) && (r[31] != a[31]); arith = 1; end
      6'h02, 6'h07: begin r = a - b; c = (a < b);
                   v = (a[31] != b[31]) && (r[31] != a[31]); arith = 1; end
      6'h03: r = a & b;
      6'h04: r = a | b;
      6'h05: r = a ^ b;
      6'h06: r = ~a;
      6'h08: r = a << s;
      6'h09: r = a >> s;
      6'h0A: r = (s == 0) ? a : ((a << s) | (a >> (32 - s)));
      6'h0B: r = (s == 0) ? a : ((a >> s) | (a << (32 - s)));
      default: ok = 1'b0;
    endcase
    if (!arith) begin c = 1'b0; v = 1'b0; end
    if (we && ok) model_flags = {v, ^r, c, (r == 32'd0)};
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; shamt = s; flag_we = we;
    e.res = r; e.wr = ok && (op != 6'h07); e.stat = {28'd0, model_flags}; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares after each edge while inputs are still stable
  always @(posedge clk) begin
    #1;
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check32(e.tag, "result", alu_result, e.res);
      check32(e.tag, "res_wr", {31'd0, res_wr}, {31'd0, e.wr});
      check32(e.tag, "status", status_word, e.stat);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check32("R10", "status in reset", status_word, 32'd0);
    @(negedge clk); rst = 1'b0;

    drive("R1", 6'h01, 32'd5, 32'd7, 0, 1);
    drive("R1 R3", 6'h01, 32'hFFFF_FFFF, 32'd1, 0, 1);
    drive("R2", 6'h01, 32'h7FFF_FFFF, 32'd1, 0, 1);
    drive("R1 borrow", 6'h02, 32'd1, 32'd2, 0, 1);
    drive("R2 sub", 6'h02, 32'h8000_0000, 32'd1, 0, 1);
    drive("R4 even", 6'h05, 32'h0000_0003, 32'd0, 0, 1);
    drive("R5 and", 6'h03, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 1);
    drive("R5 or", 6'h04, 32'h8000_0000, 32'h0000_0001, 0, 1);
    drive("R5 not", 6'h06, 32'h0000_FFFF, 32'd0, 0, 1);
    drive("R8 cmp eq", 6'h07, 32'd42, 32'd42, 0, 1);
    drive("R8 cmp lt", 6'h07, 32'd3, 32'd9, 0, 1);
    drive("R6 sll 31", 6'h08, 32'h0000_0003, 32'd0, 31, 1);
    drive("R6 srl", 6'h09, 32'h8000_0000, 32'd0, 4, 1);
    drive("R7 rol 0", 6'h0A, 32'hDEAD_BEEF, 32'd0, 0, 1);
    drive("R7 rol 31", 6'h0A, 32'h8000_0001, 32'd0, 31, 1);
    drive("R7 ror 4", 6'h0B, 32'h1234_5678, 32'd0, 4, 1);
    drive("R1 setup", 6'h01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
    drive("R9 we low", 6'h05, 32'd1, 32'd1, 0, 0);
    drive("R9 foreign", 6'h23, 32'd0, 32'd0, 0, 1);
    drive("R9 foreign2", 6'h3F, 32'h1, 32'h1, 0, 1);
    @(negedge clk); op_code = 6'h00; flag_we = 1'b0;
    repeat (3) @(posedge clk);

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 check32("R10", "status after reset", status_word, 32'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule